// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block sits beside one timer channel. It holds a single compare output state bit. When the timer reports a compare match, the bit is updated according to a two-bit output action field and to the timer's waveform mode. The same action can also be forced by software through a one-cycle strobe, so the bit can be given a known value before the pin is switched to output.

The block also chooses the value that drives the shared port pin. When the action field is non-zero, the pin value is the state bit. When the field is zero, the pin value is the general-purpose port data bit. The pin direction is always the port's direction bit, passed through unchanged. The action field is not buffered. Writing it changes the match behaviour and the pin selection straight away.

Top module: `cmp_out_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `oc_state` becomes 0, and any match or strobe in that cycle has no effect.
- R2: In normal mode (`wave_mode`=00) and CTC mode (`wave_mode`=01), a match updates `oc_state` at the next rising edge. With `cmp_mode` 01 the bit toggles, with 10 it becomes 0, and with 11 it becomes 1.
- R3: With `cmp_mode`=00, neither a match nor a strobe changes `oc_state`, in any waveform mode.
- R4: In PWM modes (`wave_mode`=10 or 11), `cmp_mode`=10 makes `oc_state` 0 on a match with `count_down`=0 and 1 on a match with `count_down`=1. `cmp_mode`=11 does the opposite. `cmp_mode`=01 takes no action.
- R5: In normal and CTC modes, a high `force_cmp` applies the configured action at the next edge. This works with `oc_pin_dir`=0, so the bit can be preset. A strobe and a match in the same cycle apply the action once, so a toggle flips the bit once.
- R6: In PWM modes, `force_cmp` has no effect on `oc_state`.
- R7: `pin_out` equals `oc_state` when `cmp_mode` is non-zero, and equals `port_data` when it is 00. This follows a change of `cmp_mode` in the same cycle, with no clock edge. The choice does not depend on `wave_mode`.
- R8: `pin_oe` always equals `port_dir`.
- R9: Without a match or an applicable strobe, `oc_state` keeps its value, including when `wave_mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wave_mode | input | 2 | 00 normal, 01 CTC, 1x PWM |
| cmp_mode | input | 2 | Output action field |
| match | input | 1 | Compare-match event from the timer |
| force_cmp | input | 1 | One-cycle force strobe |
| count_down | input | 1 | PWM count direction, 1 = counting down |
| port_data | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | Port direction bit, 1 = output |
| oc_state | output | 1 | Internal compare output state bit |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench targets a strobe and a toggle match in the same cycle. A design that adds the two events would leave the bit unchanged instead of flipping it. It uses matches in both count directions under both PWM actions, which catches a swapped direction term. It sends strobes in PWM mode and matches with a zero field, where any change of state is a fault.

The bench also changes the action field with no clock edge. A design that registers the field would show the old pin source for one cycle. Finally, it presets the bit with the direction bit low and then changes waveform modes. This exposes a design that clears the bit on a mode change or gates the strobe with the direction bit.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_CTC    = 2'b01,
    WM_PWM_A  = 2'b10,
    WM_PWM_B  = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_action_e;

  function automatic logic is_pwm(input logic [MODE_W-1:0] wm);
    return wm[MODE_W-1];
  endfunction
endpackage

// File: rtl/cmp_out_action.sv
module cmp_out_action
  import cmp_out_pkg::*;
(
  input  logic [MODE_W-1:0] wave_mode,
  input  logic [1:0]        cmp_mode,
  input  logic              match,
  input  logic              force_cmp,
  input  logic              count_down,
  output oc_action_e        action
);
  logic pwm;
  logic event_hit;

  always_comb begin
    pwm       = is_pwm(wave_mode);
    // the strobe only counts outside PWM; match and strobe merge into one event
    event_hit = match | (force_cmp & ~pwm);
    action    = ACT_NONE;
    if (event_hit) begin
      if (!pwm) begin
        unique case (cmp_mode)
          2'b01:   action = ACT_TOGGLE;
          2'b10:   action = ACT_CLEAR;
          2'b11:   action = ACT_SET;
          default: action = ACT_NONE;
        endcase
      end else begin
        unique case (cmp_mode)
          2'b10:   action = count_down ? ACT_SET : ACT_CLEAR;
          2'b11:   action = count_down ? ACT_CLEAR : ACT_SET;
          default: action = ACT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmp_out_state.sv
module cmp_out_state
  import cmp_out_pkg::*;
#(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  oc_action_e action,
  output logic       state_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_VAL;
    end else begin
      unique case (action)
        ACT_TOGGLE: state_q <= ~state_q;
        ACT_CLEAR:  state_q <= 1'b0;
        ACT_SET:    state_q <= 1'b1;
        default:    state_q <= state_q;
      endcase
    end
  end

  // R1: the first cycle after reset shows the reset value
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_q == RESET_VAL));

  // R9: no action leaves the bit alone
  assert_hold_no_action_R9: assert property (@(posedge clk) disable iff (rst)
    (action == ACT_NONE) |=> $stable(state_q));
endmodule

// File: rtl/cmp_out_pinmux.sv
module cmp_out_pinmux (
  input  logic [1:0] cmp_mode,
  input  logic       oc_bit,
  input  logic       port_data,
  input  logic       port_dir,
  output logic       pin_out,
  output logic       pin_oe
);
  logic take_oc;

  always_comb begin
    take_oc = |cmp_mode;
    pin_out = take_oc ? oc_bit : port_data;
    pin_oe  = port_dir;
  end
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic [1:0]        cmp_mode,
  input  logic              match,
  input  logic              force_cmp,
  input  logic              count_down,
  input  logic              port_data,
  input  logic              port_dir,
  output logic              oc_state,
  output logic              pin_out,
  output logic              pin_oe
);
  oc_action_e act;
  logic       st_q;

  cmp_out_action u_action (
    .wave_mode  (wave_mode),
    .cmp_mode   (cmp_mode),
    .match      (match),
    .force_cmp  (force_cmp),
    .count_down (count_down),
    .action     (act)
  );

  cmp_out_state #(.RESET_VAL(RESET_VAL)) u_state (
    .clk     (clk),
    .rst     (rst),
    .action  (act),
    .state_q (st_q)
  );

  cmp_out_pinmux u_pinmux (
    .cmp_mode  (cmp_mode),
    .oc_bit    (st_q),
    .port_data (port_data),
    .port_dir  (port_dir),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  assign oc_state = st_q;

  // R3: a zero field never moves the bit
  assert_zero_field_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode == 2'b00) |=> $stable(st_q));

  // R6: strobe without a match in PWM leaves the bit alone
  assert_pwm_force_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (is_pwm(wave_mode) && force_cmp && !match) |=> $stable(st_q));

  // R2: set action outside PWM
  assert_set_on_match_R2: assert property (@(posedge clk) disable iff (rst)
    (!is_pwm(wave_mode) && match && cmp_mode == 2'b11) |=> st_q);

  // R4: up-count clear action in PWM
  assert_pwm_up_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (is_pwm(wave_mode) && match && !count_down && cmp_mode == 2'b10) |=> !st_q);

  // R7: zero field hands the pin to the port data bit
  assert_port_source_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode == 2'b00) |-> (pin_out == port_data));
endmodule

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] wave_mode = 2'b00;
  logic [1:0] cmp_mode = 2'b00;
  logic match = 1'b0, force_cmp = 1'b0, count_down = 1'b0;
  logic port_data = 1'b0, port_dir = 1'b0;
  logic oc_state, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cmp_out_unit u_dut (
    .clk(clk), .rst(rst), .wave_mode(wave_mode), .cmp_mode(cmp_mode),
    .match(match), .force_cmp(force_cmp), .count_down(count_down),
    .port_data(port_data), .port_dir(port_dir),
    .oc_state(oc_state), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {wave_mode, cmp_mode, match, force, down, pdata, pdir, exp_state, exp_pin}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b10, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b10, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b11, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b11, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b00, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] wm, input logic [1:0] cm, input logic m,
                       input logic f, input logic d, input logic pd, input logic pr);
    wave_mode = wm; cmp_mode = cm; match = m; force_cmp = f;
    count_down = d; port_data = pd; port_dir = pr;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    // R1: reset with a toggle match pending
    @(negedge clk); drive(2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #2 check("R1", "state in reset", oc_state, 1'b0);
    @(negedge clk); rst = 1'b0; drive(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // table: R2 R3 R4 R5 R6 R9, pin via R7, direction via R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10:9], VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      @(posedge clk); #2;
      check("R2/R3/R4/R5/R6/R9", $sformatf("vector %0d state", i), oc_state, VEC[i][1]);
      check("R7", $sformatf("vector %0d pin", i), pin_out, VEC[i][0]);
      check("R8", $sformatf("vector %0d oe", i), pin_oe, VEC[i][2]);
    end

    // R7: field change takes effect with no clock edge (state is 0 here)
    @(negedge clk); drive(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    #1 check("R7", "zero field port source", pin_out, 1'b1);
    cmp_mode = 2'b01;
    #1 check("R7", "field write immediate", pin_out, 1'b0);
    wave_mode = 2'b10;
    #1 check("R7", "wave mode does not move pin source", pin_out, 1'b0);
    port_dir = 1'b0;
    #1 check("R8", "direction passthrough low", pin_oe, 1'b0);

    // R5: preset with direction low, then enable
    @(negedge clk); drive(2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #2;
    check("R5", "preset by strobe", oc_state, 1'b1);
    check("R8", "still input during preset", pin_oe, 1'b0);
    @(negedge clk); drive(2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    #1 check("R8", "enabled output", pin_oe, 1'b1);
    check("R5", "preset value on pin", pin_out, 1'b1);

    // R9: waveform mode changes keep the bit
    @(negedge clk); drive(2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #2 check("R9", "kept into PWM", oc_state, 1'b1);
    @(negedge clk); drive(2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #2 check("R9", "kept into CTC", oc_state, 1'b1);

    // R1: mid-run reset beats a set match
    @(negedge clk); rst = 1'b1; drive(2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #2 check("R1", "mid-run reset", oc_state, 1'b0);
    @(negedge clk); rst = 1'b0; drive(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #2 check("R1", "after reset release", oc_state, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule